// File: doc/BRIEF.md
# SMBus Target Register Responder

This block is the transaction layer of an SMBus target. It sits behind a target-side I2C byte engine that handles the wires, and it receives that engine's events as single-cycle pulses: bus start (including repeated start), bus stop, an address byte, a received data byte, a request for the next byte to transmit, and the host's acknowledge or not-acknowledge on a transmitted byte. For every received byte it returns an acknowledge decision. For every transmit request it returns the byte to send. Behind these events it keeps a small file of 8-bit registers, and the command byte selects which register is addressed.

The block decodes each SMBus transaction shape from the plain byte stream. A quick command is an address with no bytes after it. A send byte is a single byte after the address. Write byte and write word carry one or two bytes after the command. A receive byte is a read with no command written first. Read byte and read word are a write of the command, then a repeated start, then a read. Commands with bit 7 set are block commands: a block write carries a count byte and then data, and a block read answers with a count byte and then data. The last command is kept across transactions, so a receive byte reads the register chosen earlier. A combined write-then-read uses the command captured before the repeated start.

Top module: `smbus_reg_target`

## Requirements
- R1: After reset, ack_valid_o, tx_valid_o and quick_dir_o are 0, every register holds 0x00, the stored command is 0x00 and the stored block length is 0.
- R2: An address byte is bits [7:1] target address and bit 0 direction (1 = read). Right after a start, an address equal to own_addr_i is acknowledged. Any other address, or an address byte arriving other than right after a start, is not acknowledged. From then until the next start, data bytes are not acknowledged, no register changes and transmit requests return 0xFF.
- R3: The first data byte after a matching write address is stored as the command. Bits [4:0] give the register index and bit 7 marks a block command. A phase that carries only this byte (send byte) writes no register.
- R4: For a command with bit 7 clear, each further data byte is acknowledged and written to the register at index + k, where k = 0, 1, … and the index wraps modulo 32. A word write therefore places the low byte at index and the high byte at index + 1.
- R5: For a command with bit 7 clear, a read phase returns the registers at index, index + 1, … in order. The command persists across stop and repeated start, so a read with no command before it (receive byte) uses the last stored command.
- R6: For a block command, the byte after the command is the count. A count above 32 is not acknowledged and the target ignores the rest of the transfer until the next start. An accepted count becomes the stored block length, and the next count bytes are acknowledged and written to index + k. Bytes beyond the count are not acknowledged.
- R7: For a block command, a read phase first transmits the stored block length, then that many registers from index onward, then 0xFF.
- R8: After the host not-acknowledges a transmitted byte (host_nack_i = 1), every later transmit request returns 0xFF until the next start.
- R9: When a stop or a start ends a matching-address phase that carried no data byte and no transmit request, quick_dir_o takes that phase's direction bit. quick_dir_o changes at no other time.
- R10: ack_valid_o pulses exactly one cycle after each address or data byte event, and tx_valid_o pulses exactly one cycle after each transmit request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| own_addr_i | input | 7 | Target's own 7-bit address |
| start_i | input | 1 | Start or repeated start seen |
| stop_i | input | 1 | Stop seen |
| addr_valid_i | input | 1 | Address byte received |
| addr_byte_i | input | 8 | Address [7:1] and direction [0] |
| wr_valid_i | input | 1 | Data byte received from host |
| wr_byte_i | input | 8 | Received data byte |
| rd_req_i | input | 1 | Engine requests the next transmit byte |
| host_ack_valid_i | input | 1 | Host response on a transmitted byte is valid |
| host_nack_i | input | 1 | 1 = host NACK, 0 = host ACK |
| ack_valid_o | output | 1 | Acknowledge decision valid |
| ack_o | output | 1 | 1 = acknowledge the byte |
| tx_valid_o | output | 1 | Transmit byte valid |
| tx_byte_o | output | 8 | Byte to transmit |
| quick_dir_o | output | 1 | Direction bit of the last quick command |

## Verification
On every cycle the assertions check several rules: a foreign address is always refused, no register is written while the target ignores a transfer, an oversized block count is refused and leads to the ignore state, the stored block length never exceeds 32, requests after a host NACK return the fill byte, the quick-command flag and the command hold steady between their update events, and the input events stay mutually exclusive. Register contents, the wrap of indices, receive byte reusing an earlier command, and the count-then-data order of a block read depend on history across several transactions. Only the bench's scenarios, compared cycle by cycle against its reference model, show these.

// File: rtl/smbus_tgt_pkg.sv
package smbus_tgt_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_WRITE,
    PH_READ,
    PH_DONE,
    PH_SKIP
  } phase_e;

  typedef enum logic [1:0] {
    TX_FILL,
    TX_REG,
    TX_LEN
  } tx_src_e;

  localparam logic [7:0] FILL_BYTE = 8'hFF;
endpackage

// File: rtl/smbus_tgt_regfile.sv
module smbus_tgt_regfile #(
  parameter int NREGS = 32,
  parameter int DW    = 8,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [NREGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREGS; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/smbus_tgt_seq.sv
module smbus_tgt_seq
  import smbus_tgt_pkg::*;
#(
  parameter int NREGS   = 32,
  parameter int MAX_BLK = 32,
  localparam int AW     = $clog2(NREGS),
  localparam int LW     = $clog2(MAX_BLK + 1),
  localparam int CW     = $clog2(MAX_BLK + 2) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [6:0]    own_addr_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          addr_valid_i,
  input  logic [7:0]    addr_byte_i,
  input  logic          wr_valid_i,
  input  logic [7:0]    wr_byte_i,
  input  logic          rd_req_i,
  input  logic          host_ack_valid_i,
  input  logic          host_nack_i,
  output logic          ack_valid_o,
  output logic          ack_o,
  output logic          quick_dir_o,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [7:0]    wdata_o,
  output logic [AW-1:0] raddr_o,
  output tx_src_e       tx_src_o,
  output logic [LW-1:0] blk_len_o,
  output phase_e        phase_o
);
  localparam logic [7:0]    MAX_B8  = 8'(MAX_BLK);
  localparam logic [CW-1:0] CNT_MAX = '1;

  phase_e        ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d, cnt_inc, cnt_m1, cnt_m2;
  logic [7:0]    cmd_q, cmd_d;
  logic [LW-1:0] len_q, len_d, rem_q, rem_d;
  logic          quick_q, quick_d, ack_d;
  logic [AW-1:0] idx;
  logic          is_blk;

  assign idx     = cmd_q[AW-1:0];
  assign is_blk  = cmd_q[7];
  assign cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CW'(1);
  assign cnt_m1  = cnt_q - CW'(1);
  assign cnt_m2  = cnt_q - CW'(2);

  always_comb begin
    ph_d     = ph_q;
    cnt_d    = cnt_q;
    cmd_d    = cmd_q;
    len_d    = len_q;
    rem_d    = rem_q;
    quick_d  = quick_q;
    ack_d    = 1'b0;
    we_o     = 1'b0;
    waddr_o  = idx;
    wdata_o  = wr_byte_i;
    raddr_o  = idx;
    tx_src_o = TX_FILL;

    if (start_i || stop_i) begin
      // address-only phase: quick command
      if ((ph_q == PH_WRITE || ph_q == PH_READ) && cnt_q == '0)
        quick_d = (ph_q == PH_READ);
      ph_d  = start_i ? PH_ADDR : PH_IDLE;
      cnt_d = '0;
    end

    if (addr_valid_i) begin
      if (ph_q == PH_ADDR && addr_byte_i[7:1] == own_addr_i) begin
        ack_d = 1'b1;
        ph_d  = addr_byte_i[0] ? PH_READ : PH_WRITE;
        cnt_d = '0;
      end else begin
        ph_d = PH_SKIP;
      end
    end

    if (wr_valid_i && ph_q == PH_WRITE) begin
      cnt_d = cnt_inc;
      if (cnt_q == '0) begin
        cmd_d = wr_byte_i;
        ack_d = 1'b1;
      end else if (is_blk) begin
        if (cnt_q == CW'(1)) begin
          if (wr_byte_i > MAX_B8) begin
            ph_d = PH_SKIP;
          end else begin
            ack_d = 1'b1;
            len_d = wr_byte_i[LW-1:0];
            rem_d = wr_byte_i[LW-1:0];
          end
        end else if (rem_q != '0) begin
          ack_d   = 1'b1;
          we_o    = 1'b1;
          waddr_o = idx + AW'(cnt_m2);
          rem_d   = rem_q - LW'(1);
        end
      end else begin
        ack_d   = 1'b1;
        we_o    = 1'b1;
        waddr_o = idx + AW'(cnt_m1);
      end
    end

    if (rd_req_i && ph_q == PH_READ) begin
      cnt_d = cnt_inc;
      if (is_blk) begin
        if (cnt_q == '0) begin
          tx_src_o = TX_LEN;
        end else if (cnt_m1 < CW'(len_q)) begin
          tx_src_o = TX_REG;
          raddr_o  = idx + AW'(cnt_m1);
        end
      end else begin
        tx_src_o = TX_REG;
        raddr_o  = idx + AW'(cnt_q);
      end
    end

    if (host_ack_valid_i && host_nack_i && ph_q == PH_READ) ph_d = PH_DONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q        <= PH_IDLE;
      cnt_q       <= '0;
      cmd_q       <= '0;
      len_q       <= '0;
      rem_q       <= '0;
      quick_q     <= 1'b0;
      ack_o       <= 1'b0;
      ack_valid_o <= 1'b0;
    end else begin
      ph_q        <= ph_d;
      cnt_q       <= cnt_d;
      cmd_q       <= cmd_d;
      len_q       <= len_d;
      rem_q       <= rem_d;
      quick_q     <= quick_d;
      ack_o       <= ack_d;
      ack_valid_o <= addr_valid_i || wr_valid_i;
    end
  end

  assign quick_dir_o = quick_q;
  assign blk_len_o   = len_q;
  assign phase_o     = ph_q;

  AST_EVENT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({start_i, stop_i, addr_valid_i, wr_valid_i, rd_req_i, host_ack_valid_i})); // R10

  AST_SKIP_NO_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_SKIP) |-> !we_o); // R2

  AST_OVERSIZE_NACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && ph_q == PH_WRITE && cnt_q == CW'(1) && cmd_q[7] && wr_byte_i > MAX_B8)
    |=> (!ack_o && ph_q == PH_SKIP)); // R6

  AST_LEN_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(len_q) <= MAX_BLK); // R6

  AST_QUICK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !stop_i) |=> $stable(quick_dir_o)); // R9

  AST_CMD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_valid_i && ph_q == PH_WRITE && cnt_q == '0) |=> $stable(cmd_q)); // R5
endmodule

// File: rtl/smbus_tgt_tx.sv
module smbus_tgt_tx
  import smbus_tgt_pkg::*;
#(
  parameter int LW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  tx_src_e       src_i,
  input  logic [7:0]    reg_data_i,
  input  logic [LW-1:0] blk_len_i,
  output logic          tx_valid_o,
  output logic [7:0]    tx_byte_o
);
  logic [7:0] sel;

  always_comb begin
    unique case (src_i)
      TX_REG:  sel = reg_data_i;
      TX_LEN:  sel = 8'(blk_len_i);
      default: sel = FILL_BYTE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_valid_o <= 1'b0;
      tx_byte_o  <= FILL_BYTE;
    end else begin
      tx_valid_o <= req_i;
      if (req_i) tx_byte_o <= sel;
    end
  end
endmodule

// File: rtl/smbus_reg_target.sv
module smbus_reg_target
  import smbus_tgt_pkg::*;
#(
  parameter int NREGS   = 32,
  parameter int MAX_BLK = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [6:0] own_addr_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       addr_valid_i,
  input  logic [7:0] addr_byte_i,
  input  logic       wr_valid_i,
  input  logic [7:0] wr_byte_i,
  input  logic       rd_req_i,
  input  logic       host_ack_valid_i,
  input  logic       host_nack_i,
  output logic       ack_valid_o,
  output logic       ack_o,
  output logic       tx_valid_o,
  output logic [7:0] tx_byte_o,
  output logic       quick_dir_o
);
  localparam int AW = $clog2(NREGS);
  localparam int LW = $clog2(MAX_BLK + 1);

  logic          we;
  logic [AW-1:0] waddr, raddr;
  logic [7:0]    wdata, rdata;
  tx_src_e       tx_src;
  logic [LW-1:0] blk_len;
  phase_e        phase;

  smbus_tgt_seq #(.NREGS(NREGS), .MAX_BLK(MAX_BLK)) u_seq (
    .clk_i, .rst_ni, .own_addr_i, .start_i, .stop_i,
    .addr_valid_i, .addr_byte_i, .wr_valid_i, .wr_byte_i,
    .rd_req_i, .host_ack_valid_i, .host_nack_i,
    .ack_valid_o, .ack_o, .quick_dir_o,
    .we_o(we), .waddr_o(waddr), .wdata_o(wdata), .raddr_o(raddr),
    .tx_src_o(tx_src), .blk_len_o(blk_len), .phase_o(phase)
  );

  smbus_tgt_regfile #(.NREGS(NREGS), .DW(8)) u_regs (
    .clk_i, .rst_ni, .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
    .raddr_i(raddr), .rdata_o(rdata)
  );

  smbus_tgt_tx #(.LW(LW)) u_tx (
    .clk_i, .rst_ni, .req_i(rd_req_i), .src_i(tx_src), .reg_data_i(rdata),
    .blk_len_i(blk_len), .tx_valid_o, .tx_byte_o
  );

  AST_MISMATCH_NACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_valid_i && addr_byte_i[7:1] != own_addr_i) |=> (ack_valid_o && !ack_o)); // R2

  AST_DONE_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && phase == PH_DONE) |=> (tx_valid_o && tx_byte_o == FILL_BYTE)); // R8
endmodule

// File: tb/smbus_reg_target_test.sv
module smbus_reg_target_test;
  localparam logic [6:0] OWN = 7'h2A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 0, stop = 0, addr_v = 0, wr_v = 0, rd_req = 0, hack_v = 0, hnack = 0;
  logic [7:0] addr_b = 0, wr_b = 0;
  logic ack_valid, ack, tx_valid, quick_dir;
  logic [7:0] tx_byte;

  always #5 clk = ~clk;

  smbus_reg_target uut (
    .clk_i(clk), .rst_ni(rst_n), .own_addr_i(OWN),
    .start_i(start), .stop_i(stop), .addr_valid_i(addr_v), .addr_byte_i(addr_b),
    .wr_valid_i(wr_v), .wr_byte_i(wr_b), .rd_req_i(rd_req),
    .host_ack_valid_i(hack_v), .host_nack_i(hnack),
    .ack_valid_o(ack_valid), .ack_o(ack), .tx_valid_o(tx_valid),
    .tx_byte_o(tx_byte), .quick_dir_o(quick_dir)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // reference model: 0 idle, 1 expect addr, 2 write, 3 read, 4 after nack, 5 ignore
  int m_st, m_cnt, m_len, m_rem;
  logic [7:0] m_cmd;
  logic [7:0] m_reg [32];
  logic m_quick;
  logic e_av, e_ack, e_tv;
  logic [7:0] e_tx;
  string ack_tag, tx_tag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_len = 0; m_rem = 0; m_cmd = 0; m_quick = 0;
      foreach (m_reg[i]) m_reg[i] = 8'h00;
      e_av = 0; e_ack = 0; e_tv = 0; e_tx = 8'hFF;
      ack_tag = "R10"; tx_tag = "R10";
    end else begin
      int ix;
      ix = int'(m_cmd[4:0]);
      e_av = addr_v || wr_v;
      e_tv = rd_req;
      if (start || stop) begin
        if ((m_st == 2 || m_st == 3) && m_cnt == 0) m_quick = (m_st == 3);
        m_st = start ? 1 : 0;
        m_cnt = 0;
      end
      if (addr_v) begin
        ack_tag = "R2";
        if (m_st == 1 && addr_b[7:1] == OWN) begin
          e_ack = 1; m_st = addr_b[0] ? 3 : 2; m_cnt = 0;
        end else begin
          e_ack = 0; m_st = 5;
        end
      end
      if (wr_v) begin
        e_ack = 0;
        ack_tag = "R2";
        if (m_st == 2) begin
          if (m_cnt == 0) begin
            m_cmd = wr_b; e_ack = 1; ack_tag = "R3";
          end else if (m_cmd[7]) begin
            ack_tag = "R6";
            if (m_cnt == 1) begin
              if (wr_b > 8'd32) m_st = 5;
              else begin e_ack = 1; m_len = int'(wr_b); m_rem = int'(wr_b); end
            end else if (m_rem > 0) begin
              e_ack = 1; m_reg[(ix + m_cnt - 2) % 32] = wr_b; m_rem--;
            end
          end else begin
            ack_tag = "R4";
            e_ack = 1; m_reg[(ix + m_cnt - 1) % 32] = wr_b;
          end
          m_cnt++;
        end
      end
      if (rd_req) begin
        e_tx = 8'hFF;
        tx_tag = (m_st == 4) ? "R8" : "R2";
        if (m_st == 3) begin
          if (m_cmd[7]) begin
            tx_tag = "R7";
            if (m_cnt == 0) e_tx = 8'(m_len);
            else if (m_cnt - 1 < m_len) e_tx = m_reg[(ix + m_cnt - 1) % 32];
          end else begin
            tx_tag = "R5";
            e_tx = m_reg[(ix + m_cnt) % 32];
          end
          m_cnt++;
        end
      end
      if (hack_v && hnack && m_st == 3) m_st = 4;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_cmp++;
      if (ack_valid !== e_av) begin
        n_bad++; $display("FAIL R10: ack_valid_o got %0b exp %0b", ack_valid, e_av);
      end
      n_cmp++;
      if (tx_valid !== e_tv) begin
        n_bad++; $display("FAIL R10: tx_valid_o got %0b exp %0b", tx_valid, e_tv);
      end
      n_cmp++;
      if (quick_dir !== m_quick) begin
        n_bad++; $display("FAIL R9: quick_dir_o got %0b exp %0b", quick_dir, m_quick);
      end
      if (e_av) begin
        n_cmp++;
        if (ack !== e_ack) begin
          n_bad++; $display("FAIL %s: ack_o got %0b exp %0b", ack_tag, ack, e_ack);
        end
      end
      if (e_tv) begin
        n_cmp++;
        if (tx_byte !== e_tx) begin
          n_bad++; $display("FAIL %s: tx_byte_o got %02h exp %02h", tx_tag, tx_byte, e_tx);
        end
      end
    end
  end

  task automatic t_start(); @(negedge clk) start = 1; @(negedge clk) start = 0; endtask
  task automatic t_stop();  @(negedge clk) stop = 1;  @(negedge clk) stop = 0;  endtask
  task automatic t_addr(input logic [6:0] a, input logic rw);
    @(negedge clk) begin addr_v = 1; addr_b = {a, rw}; end
    @(negedge clk) addr_v = 0;
  endtask
  task automatic t_byte(input logic [7:0] b);
    @(negedge clk) begin wr_v = 1; wr_b = b; end
    @(negedge clk) wr_v = 0;
  endtask
  task automatic t_req(); @(negedge clk) rd_req = 1; @(negedge clk) rd_req = 0; endtask
  task automatic t_hack(input logic nack);
    @(negedge clk) begin hack_v = 1; hnack = nack; end
    @(negedge clk) hack_v = 0;
  endtask
  task automatic t_read(input logic [7:0] cmd, input int n);
    t_start(); t_addr(OWN, 0); t_byte(cmd);
    t_start(); t_addr(OWN, 1);
    for (int i = 0; i < n; i++) begin t_req(); t_hack(i == n - 1); end
    t_req(); t_stop();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    n_cmp++;
    if (ack_valid !== 0 || tx_valid !== 0 || quick_dir !== 0) begin
      n_bad++; $display("FAIL R1: outputs got %0b%0b%0b exp 000", ack_valid, tx_valid, quick_dir);
    end
    // R1: receive byte after reset reads register 0 = 0x00
    t_start(); t_addr(OWN, 1); t_req(); t_hack(1); t_stop();
    // R9: quick commands both directions
    t_start(); t_addr(OWN, 1); t_stop();
    t_start(); t_addr(OWN, 0); t_stop();
    t_start(); t_addr(OWN, 1); t_start(); t_addr(OWN, 0); t_byte(8'h00); t_stop();
    // R3/R4: write byte, write word
    t_start(); t_addr(OWN, 0); t_byte(8'h03); t_byte(8'hA5); t_stop();
    t_start(); t_addr(OWN, 0); t_byte(8'h05); t_byte(8'h34); t_byte(8'h12); t_stop();
    // R5/R8: read word then extra request after NACK
    t_read(8'h05, 2);
    // R3/R5: send byte then receive byte
    t_start(); t_addr(OWN, 0); t_byte(8'h03); t_stop();
    t_start(); t_addr(OWN, 1); t_req(); t_hack(1); t_stop();
    // R2: foreign address ignored
    t_start(); t_addr(OWN ^ 7'h01, 0); t_byte(8'h05); t_byte(8'h77); t_req(); t_stop();
    t_addr(OWN, 0); t_byte(8'h05); t_stop();
    t_read(8'h05, 2);
    // R6/R7: block write with extra byte, block read
    t_start(); t_addr(OWN, 0); t_byte(8'h81); t_byte(8'd3);
    t_byte(8'h11); t_byte(8'h22); t_byte(8'h33); t_byte(8'h44); t_stop();
    t_read(8'h81, 5);
    // R6: oversize count refused
    t_start(); t_addr(OWN, 0); t_byte(8'h81); t_byte(8'd33); t_byte(8'h55); t_stop();
    t_read(8'h81, 4);
    // R6/R7: maximum count with index wrap
    t_start(); t_addr(OWN, 0); t_byte(8'h9E); t_byte(8'd32);
    for (int i = 0; i < 32; i++) t_byte(8'(i * 3 + 1));
    t_stop();
    t_read(8'h9E, 34);
    // R4: word wrap at last register
    t_start(); t_addr(OWN, 0); t_byte(8'h1F); t_byte(8'hAB); t_byte(8'hCD); t_stop();
    t_read(8'h1F, 2);
    // mixed traffic
    void'($urandom(32'd11));
    for (int k = 0; k < 60; k++) begin
      int op;
      logic [7:0] c;
      op = int'($urandom_range(0, 5));
      c = 8'($urandom_range(0, 31));
      case (op)
        0: begin t_start(); t_addr(OWN, 0); t_byte(c); t_byte(8'($urandom)); t_byte(8'($urandom)); t_stop(); end
        1: t_read(c, 2);
        2: begin t_start(); t_addr(OWN, 0); t_byte(c); t_stop(); end
        3: begin t_start(); t_addr(OWN, 1); t_req(); t_hack(1); t_stop(); end
        4: begin t_start(); t_addr(7'h11, 0); t_byte(c); t_byte(8'h99); t_stop(); end
        default: begin
          int n;
          n = int'($urandom_range(0, 6));
          t_start(); t_addr(OWN, 0); t_byte(c | 8'h80); t_byte(8'(n));
          for (int i = 0; i < n + 1; i++) t_byte(8'($urandom));
          t_stop();
          t_read(c | 8'h80, n + 2);
        end
      endcase
    end
    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL R10: watchdog expired got running exp finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule